// File: doc/BRIEF.md
# Configurable Register Logic Cell

A single logic cell of a programmable array. The array supplies the cell with sum terms: a data term (D, T or J), a second data term (K), a clock term, local reset and preset terms and an output-enable term. Per-cell configuration inputs pick the storage behaviour, the clock source and its polarity, and whether reset and preset come from the shared global lines or from the cell's own sum terms.

The cell runs entirely in the system clock domain `clk_i`. The global clocks and the array clock term are treated as level signals. The cell samples them every system cycle and acts on a detected rising edge of the selected, polarity-adjusted source, or on its high level when the cell is a latch. The cell has three outputs. The pin output carries the registered value or the combinational data sum and is gated by the output enable. The feedback output carries the stored value back to the array. The buried data output passes the data sum to the companion I/O register.

Top module: `logic_cell`

## Requirements
- R1: While `rst_ni` is low, `fb_o` is 0. After release the cell ignores a source that is already high until it has seen that source low.
- R2: Mode 0 (D). On a rising edge of the active cell clock, the stored value takes `d_sum_i`.
- R3: Mode 1 (T). On an active edge the stored value inverts when `d_sum_i` is 1 and holds when it is 0. With `d_sum_i` held at 1 the output runs at half the rate of the cell clock.
- R4: Mode 2 (JK), with J=`d_sum_i` and K=`k_sum_i`. On an active edge the cell holds for J=0 K=0, clears for J=0 K=1, sets for J=1 K=0 and inverts for J=1 K=1.
- R5: Mode 3 (latch). While the active clock level is 1, the stored value follows `d_sum_i` one system cycle later. While the level is 0 it holds.
- R6: A `clk_sel_i` value k below NUM_GCLK selects `gclk_i[k]`. Larger values select `clk_sum_i`. Sources that are not selected have no effect.
- R7: With `clk_inv_i`=1 the source is inverted before edge detection, so the cell acts on its falling edge or on its low level.
- R8: The effective reset is `rst_sum_i` when `rst_local_i`=1 and `grst_i` otherwise. When it is active, `fb_o` is 0 after the next system clock edge, whatever the cell clock does.
- R9: The effective preset is `pre_sum_i` when `pre_local_i`=1 and `gpre_i` otherwise. When it is active and the reset is not, `fb_o` is 1 after the next system edge.
- R10: When reset and preset are active together, reset wins.
- R11: With `oe_sum_i`=1, `pin_o` carries `fb_o` when `out_sel_i`=0 and `d_sum_i` when `out_sel_i`=1, and `pin_z_o`=0. With `oe_sum_i`=0, `pin_z_o`=1 and `pin_o`=0, while `fb_o` and `io_d_o` are unaffected.
- R12: `io_d_o` always equals `d_sum_i` combinationally, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gclk_i | input | NUM_GCLK | Global clock levels |
| grst_i | input | 1 | Global reset |
| gpre_i | input | 1 | Global preset |
| d_sum_i | input | 1 | Data sum term (D, T or J) |
| k_sum_i | input | 1 | K sum term |
| clk_sum_i | input | 1 | Array clock sum term |
| rst_sum_i | input | 1 | Local reset sum term |
| pre_sum_i | input | 1 | Local preset sum term |
| oe_sum_i | input | 1 | Output enable sum term, active high |
| mode_i | input | 2 | Storage mode: 0 D, 1 T, 2 JK, 3 latch |
| clk_sel_i | input | CSW | Clock source select |
| clk_inv_i | input | 1 | Clock polarity invert |
| rst_local_i | input | 1 | 1 selects the local reset |
| pre_local_i | input | 1 | 1 selects the local preset |
| out_sel_i | input | 1 | Pin source: 0 registered, 1 combinational |
| pin_o | output | 1 | Pin value |
| pin_z_o | output | 1 | High-impedance indication |
| fb_o | output | 1 | Registered feedback to the array |
| io_d_o | output | 1 | Data sum routed to the companion I/O register |

## Verification
Every mode is run under every clock source and both polarities. The selected source toggles every two cycles while the unselected sources toggle every cycle, so a mux that picks the wrong source, or an edge detector that misses an edge or fires twice, shows up against the expected waveform. The data and K terms step through all four combinations at successive edges. This separates hold from clear, set and invert, and the data term also changes while the level is high, which shows whether the latch is transparent. A sweep over all reset and preset source combinations checks the priority and the source choice. An output sweep over enable, pin select and data checks the pin path and the buried path.

// File: rtl/cell_pkg.sv
package cell_pkg;
  typedef enum logic [1:0] {
    MODE_D     = 2'd0,
    MODE_T     = 2'd1,
    MODE_JK    = 2'd2,
    MODE_LATCH = 2'd3
  } cell_mode_e;
endpackage

// File: rtl/cell_clk_src.sv
module cell_clk_src #(
  parameter int NUM_GCLK = 2,
  localparam int CSW = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                arr_clk_i,
  input  logic [CSW-1:0]      sel_i,
  input  logic                inv_i,
  output logic                lvl_o,
  output logic                rise_o
);
  logic src;
  logic lvl_q;

  always_comb begin
    src = arr_clk_i;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (sel_i == CSW'(i)) src = gclk_i[i];
    end
  end

  assign lvl_o = src ^ inv_i;

  // reset to 1: a source already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~lvl_q;
endmodule

// File: rtl/cell_next.sv
module cell_next
  import cell_pkg::*;
(
  input  cell_mode_e mode_i,
  input  logic       q_i,
  input  logic       d_i,
  input  logic       k_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       rst_act_i,
  input  logic       pre_act_i,
  output logic       q_nxt_o
);
  logic clocked;

  always_comb begin
    clocked = q_i;
    unique case (mode_i)
      MODE_D:     if (rise_i) clocked = d_i;
      MODE_T:     if (rise_i && d_i) clocked = ~q_i;
      MODE_JK: begin
        if (rise_i) begin
          unique case ({d_i, k_i})
            2'b00: clocked = q_i;
            2'b01: clocked = 1'b0;
            2'b10: clocked = 1'b1;
            2'b11: clocked = ~q_i;
          endcase
        end
      end
      MODE_LATCH: if (lvl_i) clocked = d_i;
    endcase
  end

  // reset over preset over clocked data
  assign q_nxt_o = rst_act_i ? 1'b0 : (pre_act_i ? 1'b1 : clocked);
endmodule

// File: rtl/cell_out.sv
module cell_out (
  input  logic q_i,
  input  logic d_i,
  input  logic oe_i,
  input  logic sel_comb_i,
  output logic pin_o,
  output logic pin_z_o,
  output logic fb_o,
  output logic io_d_o
);
  logic pin_src;

  assign pin_src = sel_comb_i ? d_i : q_i;
  assign pin_o   = oe_i & pin_src;
  assign pin_z_o = ~oe_i;
  assign fb_o    = q_i;
  assign io_d_o  = d_i;
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import cell_pkg::*;
#(
  parameter int NUM_GCLK = 2,
  localparam int CSW = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                grst_i,
  input  logic                gpre_i,
  input  logic                d_sum_i,
  input  logic                k_sum_i,
  input  logic                clk_sum_i,
  input  logic                rst_sum_i,
  input  logic                pre_sum_i,
  input  logic                oe_sum_i,
  input  logic [1:0]          mode_i,
  input  logic [CSW-1:0]      clk_sel_i,
  input  logic                clk_inv_i,
  input  logic                rst_local_i,
  input  logic                pre_local_i,
  input  logic                out_sel_i,
  output logic                pin_o,
  output logic                pin_z_o,
  output logic                fb_o,
  output logic                io_d_o
);
  logic lvl, rise, rst_act, pre_act, q_q, q_nxt;

  cell_clk_src #(.NUM_GCLK(NUM_GCLK)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gclk_i    (gclk_i),
    .arr_clk_i (clk_sum_i),
    .sel_i     (clk_sel_i),
    .inv_i     (clk_inv_i),
    .lvl_o     (lvl),
    .rise_o    (rise)
  );

  assign rst_act = rst_local_i ? rst_sum_i : grst_i;
  assign pre_act = pre_local_i ? pre_sum_i : gpre_i;

  cell_next u_next (
    .mode_i    (cell_mode_e'(mode_i)),
    .q_i       (q_q),
    .d_i       (d_sum_i),
    .k_i       (k_sum_i),
    .lvl_i     (lvl),
    .rise_i    (rise),
    .rst_act_i (rst_act),
    .pre_act_i (pre_act),
    .q_nxt_o   (q_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_nxt;
  end

  cell_out u_out (
    .q_i        (q_q),
    .d_i        (d_sum_i),
    .oe_i       (oe_sum_i),
    .sel_comb_i (out_sel_i),
    .pin_o      (pin_o),
    .pin_z_o    (pin_z_o),
    .fb_o       (fb_o),
    .io_d_o     (io_d_o)
  );
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic grst_i,
  input logic gpre_i,
  input logic rst_sum_i,
  input logic pre_sum_i,
  input logic rst_local_i,
  input logic pre_local_i,
  input logic oe_sum_i,
  input logic d_sum_i,
  input logic pin_o,
  input logic pin_z_o,
  input logic fb_o,
  input logic io_d_o
);
  logic rst_eff, pre_eff;
  assign rst_eff = rst_local_i ? rst_sum_i : grst_i;
  assign pre_eff = pre_local_i ? pre_sum_i : gpre_i;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |=> !fb_o);

  // R8 R10
  reset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_eff |=> !fb_o);

  // R9
  preset_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_eff && !rst_eff) |=> fb_o);

  // R11
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_sum_i |-> (pin_z_o && !pin_o));

  // R12
  buried_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_d_o == d_sum_i);
endmodule

bind logic_cell logic_cell_chk u_chk (.*);

// File: tb/logic_cell_tb.sv
module logic_cell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_GCLK = 2;
  localparam int CSW = $clog2(NUM_GCLK + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NUM_GCLK-1:0] gclk_i = '0;
  logic grst_i = 0, gpre_i = 0, d_sum_i = 0, k_sum_i = 0, clk_sum_i = 0;
  logic rst_sum_i = 0, pre_sum_i = 0, oe_sum_i = 1;
  logic [1:0] mode_i = 0;
  logic [CSW-1:0] clk_sel_i = 0;
  logic clk_inv_i = 0, rst_local_i = 0, pre_local_i = 0, out_sel_i = 0;
  logic pin_o, pin_z_o, fb_o, io_d_o;

  int n_vec = 0, n_err = 0;
  logic m_q = 0, m_plvl = 1;
  string tag;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic_cell #(.NUM_GCLK(NUM_GCLK)) u_dut (.*);

  task automatic chk(string t, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0b exp=%0b", t, act, exp);
    end
  endtask

  // one system cycle: model update at posedge from inputs driven at negedge
  task automatic tick();
    logic src, lvl, rise, ra, pa;
    @(posedge clk_i);
    src = (clk_sel_i < CSW'(NUM_GCLK)) ? gclk_i[clk_sel_i] : clk_sum_i;
    lvl = src ^ clk_inv_i;
    rise = lvl & ~m_plvl;
    ra = rst_local_i ? rst_sum_i : grst_i;
    pa = pre_local_i ? pre_sum_i : gpre_i;
    if (!rst_ni) begin m_q = 0; m_plvl = 1; end
    else begin
      m_plvl = lvl;
      if (ra) m_q = 0;
      else if (pa) m_q = 1;
      else case (mode_i)
        2'd0: if (rise) m_q = d_sum_i;
        2'd1: if (rise && d_sum_i) m_q = ~m_q;
        2'd2: if (rise) m_q = d_sum_i ? (k_sum_i ? ~m_q : 1'b1) : (k_sum_i ? 1'b0 : m_q);
        default: if (lvl) m_q = d_sum_i;
      endcase
    end
    @(negedge clk_i);
    chk(tag, fb_o, m_q);
    chk("R11 pin", pin_o, oe_sum_i & (out_sel_i ? d_sum_i : m_q));
    chk("R11 pin_z", pin_z_o, ~oe_sum_i);
    chk("R12 io_d", io_d_o, d_sum_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0; tag = "R1 reset";
    tick();
    @(negedge clk_i); rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    tag = "R1 reset";
    tick();
    chk("R1 reset fb", fb_o, 1'b0);
    // clock sweep: R2..R7
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 3; s++)
        for (int iv = 0; iv < 2; iv++) begin
          mode_i = 2'(m); clk_sel_i = CSW'(s); clk_inv_i = iv[0];
          do_reset();
          tag = $sformatf("%s/R6/R7 mode=%0d sel=%0d inv=%0d",
                          m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5", m, s, iv);
          for (int t = 0; t < 32; t++) begin
            logic slow, fast;
            slow = t[1]; fast = t[0];
            gclk_i[0] = (s == 0) ? slow : fast;
            gclk_i[1] = (s == 1) ? slow : ~fast;
            clk_sum_i = (s == 2) ? slow : fast;
            d_sum_i = t[3] ^ t[0];
            k_sum_i = t[4];
            tick();
            @(negedge clk_i);
          end
        end
    // divide by two: R3
    mode_i = 2'd1; clk_sel_i = 0; clk_inv_i = 0; do_reset();
    d_sum_i = 1; tag = "R3 divide";
    for (int t = 0; t < 16; t++) begin
      gclk_i[0] = t[0]; tick(); @(negedge clk_i);
    end
    // reset/preset sweep: R8 R9 R10
    mode_i = 2'd0; gclk_i = '0; clk_sum_i = 0;
    for (int v = 0; v < 64; v++) begin
      do_reset();
      d_sum_i = v[0]; // level of toggle pattern into state first
      gpre_i = 1; pre_local_i = 0; tag = "R9 pre"; tick();
      @(negedge clk_i);
      gpre_i = 0;
      {grst_i, gpre_i, rst_sum_i, pre_sum_i, rst_local_i, pre_local_i} = 6'(v);
      tag = $sformatf("R8/R9/R10 v=%0d", v);
      tick();
      @(negedge clk_i);
      {grst_i, gpre_i, rst_sum_i, pre_sum_i, rst_local_i, pre_local_i} = '0;
    end
    // output sweep: R11 R12
    for (int v = 0; v < 32; v++) begin
      {oe_sum_i, out_sel_i, d_sum_i, mode_i} = 5'(v);
      gclk_i[0] = v[0];
      tag = "R11 fb"; tick(); @(negedge clk_i);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule